// File: doc/BRIEF.md
# Addressable Step-Attenuator Control Front End

This block is the digital control front end of a 7-bit step attenuator. It produces a registered attenuation code, in quarter-decibel units, that drives the switch array. The code can be loaded in two ways. In serial mode, a three-wire stream of data, shift clock and latch strobe loads the code, and several devices can share that bus. In parallel mode, a 7-bit word loads the code, either directly or captured by the latch strobe. A single mode input selects serial or parallel operation.

In serial mode each frame is 16 bits. The attenuation byte is sent first, then the address byte, and each byte goes least-significant bit first. On the rising edge of the latch strobe the frame is applied only if two conditions hold: the low three bits of the address byte equal the strapped device address, and the guard bit on top of the attenuation byte is clear. Otherwise the output keeps its value. All serial and parallel inputs come from outside the clock domain, so they are synchronised to the block clock and edge-detected there. The block leaves reset at maximum attenuation.

Top module: `atten_ctl`

## Requirements
- R1: While reset is active, and on the first cycles after it is released, `atten_out` is 127 (all ones, 31.75 dB).
- R2: In serial mode, each rising edge of `sclk` taken while `latch_en` is low shifts `sdata` into a 16-bit frame. The first bit shifted lands in bit 0 after 16 shifts. Bits 7:0 form the attenuation byte and bits 15:8 form the address byte.
- R3: On a rising `latch_en` in serial mode, frame bits 6:0 are loaded into `atten_out` when the address and guard bits allow it. Every code from 0 to 127 is accepted.
- R4: If frame bits 10:8 differ from `strap_addr`, a rising `latch_en` leaves `atten_out` unchanged.
- R5: Frame bits 15:11 do not take part in the address match.
- R6: If frame bit 7 is set, the frame is rejected and `atten_out` is unchanged.
- R7: While `latch_en` is high, `sclk` edges do not shift, so a later latch strobe re-applies the frame held before.
- R8: In parallel mode (`mode_ser` = 0) with `latch_en` high, `atten_out` follows `par_word` and tracks every change of it.
- R9: In parallel mode with `latch_en` low, `atten_out` holds the last value `par_word` had while `latch_en` was high.
- R10: In serial mode, `par_word` has no effect on `atten_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_ser | input | 1 | 1 selects serial-addressable mode, 0 selects parallel mode |
| sclk | input | 1 | Serial shift clock, sampled and edge-detected |
| sdata | input | 1 | Serial data, captured on the rising `sclk` |
| latch_en | input | 1 | Latch strobe; in parallel mode a high level makes the output transparent |
| par_word | input | 7 | Parallel attenuation code |
| strap_addr | input | 3 | Strapped device address |
| atten_out | output | 7 | Registered attenuation code for the switch array |

## Verification
On every cycle the assertions check the following:
- The state at reset release.
- That a shift moves the frame by one position.
- That the frame is frozen while the strobe is high.
- That the output holds whenever no load is allowed: a mismatching address, a set guard bit, or parallel mode with the strobe low.
- That it loads the right value when a load is allowed.

Only the bench scenarios can show the end-to-end ordering: that a byte sent least-significant bit first comes out as the intended code, that the address bits above the compared three are ignored, and that a frame clocked in while the strobe was high does not replace the one held before.

// File: rtl/atten_ctl_pkg.sv
package atten_ctl_pkg;
  localparam int unsigned CODE_W_DEF  = 7;
  localparam int unsigned ADDR_W_DEF  = 3;
  localparam int unsigned FIELD_W_DEF = 8;
  localparam int unsigned SYNC_N_DEF  = 2;
endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = din;
    for (int i = 1; i < STAGES; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/atten_edge.sv
module atten_edge #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= level;
    end
  end

  assign rise = level & ~prev_q;
endmodule

// File: rtl/atten_shift.sv
module atten_shift #(
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               bit_in,
  output logic [FIELD_W-1:0] att_field,
  output logic [ADDR_W-1:0]  addr_lo
);
  localparam int unsigned SHIFT_W = 2 * FIELD_W;

  logic [SHIFT_W-1:0] frame_q;
  logic [SHIFT_W-1:0] frame_d;

  always_comb begin
    frame_d = frame_q;
    if (shift_en) begin
      frame_d = {bit_in, frame_q[SHIFT_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
    end else begin
      frame_q <= frame_d;
    end
  end

  assign att_field = frame_q[FIELD_W-1:0];
  assign addr_lo   = frame_q[FIELD_W +: ADDR_W];
endmodule

// File: rtl/atten_outreg.sv
module atten_outreg #(
  parameter int unsigned CODE_W  = 7,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_ser,
  input  logic               le_level,
  input  logic               le_rise,
  input  logic [CODE_W-1:0]  par_code,
  input  logic [FIELD_W-1:0] att_field,
  input  logic [ADDR_W-1:0]  addr_lo,
  input  logic [ADDR_W-1:0]  strap_addr,
  output logic [CODE_W-1:0]  code_q
);
  logic              guard_set;
  logic              addr_hit;
  logic              load;
  logic [CODE_W-1:0] load_val;
  logic [CODE_W-1:0] code_d;

  always_comb begin
    guard_set = |att_field[FIELD_W-1:CODE_W];
    addr_hit  = (addr_lo == strap_addr);
    if (mode_ser) begin
      load     = le_rise && addr_hit && !guard_set;
      load_val = att_field[CODE_W-1:0];
    end else begin
      load     = le_level;
      load_val = par_code;
    end
    code_d = load ? load_val : code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '1;
    end else begin
      code_q <= code_d;
    end
  end
endmodule

// File: rtl/atten_ctl.sv
module atten_ctl
  import atten_ctl_pkg::*;
#(
  parameter int unsigned CODE_W  = CODE_W_DEF,
  parameter int unsigned ADDR_W  = ADDR_W_DEF,
  parameter int unsigned FIELD_W = FIELD_W_DEF,
  parameter int unsigned SYNC_N  = SYNC_N_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ser,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              latch_en,
  input  logic [CODE_W-1:0] par_word,
  input  logic [ADDR_W-1:0] strap_addr,
  output logic [CODE_W-1:0] atten_out
);
  localparam int unsigned SYNC_W = CODE_W + 4;

  logic [1:0]         rst_pipe_q;
  logic               rst_sync_n;
  logic [SYNC_W-1:0]  raw_bus;
  logic [SYNC_W-1:0]  sync_bus;
  logic               s_mode;
  logic               s_le;
  logic               s_sclk;
  logic               s_data;
  logic [CODE_W-1:0]  s_par;
  logic               le_rise;
  logic               sclk_rise;
  logic               shift_en;
  logic [FIELD_W-1:0] att_field;
  logic [ADDR_W-1:0]  addr_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign raw_bus = {mode_ser, latch_en, sclk, sdata, par_word};

  atten_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_N)) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .din  (raw_bus),
    .dout (sync_bus)
  );

  assign {s_mode, s_le, s_sclk, s_data, s_par} = sync_bus;

  atten_edge #(.WIDTH(2)) u_edge (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .level({s_le, s_sclk}),
    .rise ({le_rise, sclk_rise})
  );

  assign shift_en = s_mode && sclk_rise && !s_le;

  atten_shift #(.FIELD_W(FIELD_W), .ADDR_W(ADDR_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .shift_en (shift_en),
    .bit_in   (s_data),
    .att_field(att_field),
    .addr_lo  (addr_lo)
  );

  atten_outreg #(.CODE_W(CODE_W), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .mode_ser  (s_mode),
    .le_level  (s_le),
    .le_rise   (le_rise),
    .par_code  (s_par),
    .att_field (att_field),
    .addr_lo   (addr_lo),
    .strap_addr(strap_addr),
    .code_q    (atten_out)
  );
endmodule

// File: rtl/atten_ctl_chk.sv
module atten_ctl_chk #(
  parameter int unsigned CODE_W  = 7,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned FIELD_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rst_sync_n,
  input logic               s_mode,
  input logic               s_le,
  input logic [CODE_W-1:0]  s_par,
  input logic               le_rise,
  input logic               sclk_rise,
  input logic [FIELD_W-1:0] att_field,
  input logic [ADDR_W-1:0]  addr_lo,
  input logic [ADDR_W-1:0]  strap_addr,
  input logic [CODE_W-1:0]  atten_out
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> atten_out == {CODE_W{1'b1}});

  assert_shift_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_mode && sclk_rise && !s_le) |=>
      att_field == {$past(addr_lo[0]), $past(att_field[FIELD_W-1:1])});

  assert_apply_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_mode && le_rise && att_field[FIELD_W-1:CODE_W] == '0 && addr_lo == strap_addr) |=>
      atten_out == $past(att_field[CODE_W-1:0]));

  assert_addr_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s_mode && le_rise && addr_lo != strap_addr) |=> $stable(atten_out));

  assert_guard_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_mode && le_rise && |att_field[FIELD_W-1:CODE_W]) |=> $stable(atten_out));

  assert_frozen_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s_mode && s_le) |=> $stable(att_field) && $stable(addr_lo));

  assert_par_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_mode && s_le) |=> atten_out == $past(s_par));

  assert_par_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_mode && !s_le) |=> $stable(atten_out));

  assert_serial_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_mode && !le_rise) |=> $stable(atten_out));
endmodule

bind atten_ctl atten_ctl_chk #(.CODE_W(CODE_W), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_chk (.*);

// File: tb/atten_ctl_test.sv
`timescale 1ns/1ps
module atten_ctl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       mode_ser = 1'b1;
  logic       sclk = 1'b0;
  logic       sdata = 1'b0;
  logic       latch_en = 1'b0;
  logic [6:0] par_word = 7'd0;
  logic [2:0] strap_addr = 3'd5;
  logic [6:0] atten_out;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    started = 1'b0;
  bit    done = 1'b0;

  always #4 clk = ~clk;

  atten_ctl uut (
    .clk(clk), .rst_n(rst_n), .mode_ser(mode_ser), .sclk(sclk), .sdata(sdata),
    .latch_en(latch_en), .par_word(par_word), .strap_addr(strap_addr),
    .atten_out(atten_out)
  );

  // Behavioural reference: a queue of input samples stands in for the input latency.
  logic [10:0] hist[$];
  logic [10:0] cur_s, old_s;
  int          rel_cnt;
  logic [15:0] m_frame;
  logic [6:0]  m_out;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{11'd0, 11'd0, 11'd0};
      rel_cnt = 0;
      m_frame = 16'd0;
      m_out = 7'h7F;
      started = 1'b1;
    end else if (rel_cnt < 2) begin
      rel_cnt++;
    end else begin
      cur_s = hist[1];
      old_s = hist[2];
      if (cur_s[10]) begin
        if (cur_s[9] && !old_s[9] && !m_frame[7] && m_frame[10:8] == strap_addr)
          m_out = m_frame[6:0];
        if (cur_s[8] && !old_s[8] && !cur_s[9])
          m_frame = {cur_s[7], m_frame[15:1]};
      end else if (cur_s[9]) begin
        m_out = cur_s[6:0];
      end
      hist.push_front({mode_ser, latch_en, sclk, sdata, par_word});
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (atten_out !== m_out) begin
        errors++;
        $display("FAIL %s model mismatch at %0t: got %0d expected %0d", cur_req, $time, atten_out, m_out);
      end
    end
  end

  task automatic check(input string req, input logic [6:0] exp);
    checks++;
    if (atten_out !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, atten_out, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic shift_bits(input logic [15:0] w);
    for (int i = 0; i < 16; i++) begin
      step(1);
      sdata = w[i];
      step(3);
      sclk = 1'b1;
      step(3);
      sclk = 1'b0;
    end
  endtask

  task automatic pulse_latch();
    step(3);
    latch_en = 1'b1;
    step(4);
    latch_en = 1'b0;
    step(6);
  endtask

  task automatic send_word(input logic [7:0] att, input logic [7:0] adr);
    shift_bits({adr, att});
    pulse_latch();
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    step(4);
    cur_req = "R1"; check("R1", 7'd127);
    rst_n = 1'b1;
    step(10);
    check("R1", 7'd127);

    cur_req = "R3"; send_word(8'd37, 8'h05); check("R3", 7'd37);
    cur_req = "R2"; send_word(8'h0B, 8'h05); check("R2", 7'd11);
    cur_req = "R4"; send_word(8'd60, 8'h03); check("R4", 7'd11);
    cur_req = "R5"; send_word(8'd90, 8'hF5); check("R5", 7'd90);
    cur_req = "R6"; send_word(8'h8C, 8'h05); check("R6", 7'd90);

    cur_req = "R7"; send_word(8'd20, 8'h05); check("R7", 7'd20);
    step(2);
    latch_en = 1'b1;
    shift_bits({8'h05, 8'd50});
    latch_en = 1'b0;
    step(6);
    pulse_latch();
    check("R7", 7'd20);

    cur_req = "R3"; send_word(8'd0, 8'h05);   check("R3", 7'd0);
    send_word(8'd127, 8'h05); check("R3", 7'd127);
    send_word(8'd0, 8'h05);   check("R3", 7'd0);

    cur_req = "R10"; par_word = 7'd77; step(10); check("R10", 7'd0);

    cur_req = "R9"; mode_ser = 1'b0; step(8); check("R9", 7'd0);
    cur_req = "R8"; latch_en = 1'b1; step(8); check("R8", 7'd77);
    par_word = 7'd99; step(6); check("R8", 7'd99);
    cur_req = "R9"; latch_en = 1'b0; step(6);
    par_word = 7'd44; step(6); check("R9", 7'd99);
    latch_en = 1'b1; step(6); latch_en = 1'b0; step(2);
    par_word = 7'd3; step(6); check("R9", 7'd44);

    cur_req = "R1"; rst_n = 1'b0; step(3); check("R1", 7'd127);
    rst_n = 1'b1; step(10); check("R1", 7'd127);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule